// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block steps through the states of one access to an external static-memory region. It accepts a request that carries a region number, a read/write flag and a cycle-type flag. The cycle-type flag marks a DMA single-mode transfer, as distinct from a CPU or DMA dual-mode transfer. From the request the block settles the shape of the access and then walks it state by state, one clock per state. It holds the chip-select/address window, the read strobe and the byte-lane strobes for the whole access, and it pulses a done flag in the final state.

Regions fall into two families. The short family is regions 1, 3, 4, 5 and 7. Its access is either one state, or two states stretched by the active-low wait pin. The long family is regions 0, 2 and 6. Its access is one state plus a programmed run of 1 to 4 long-wait states, and it may also be stretched by the wait pin just before the last long wait. Two per-region enable masks decide whether the wait pin is honoured: one for CPU and dual-mode reads, one for single-mode transfers. CPU and dual-mode writes always honour the pin. Region 3 never honours it. A mode input chooses between two meanings for the three byte-lane pins of a 16-bit bus.

Top module: `xbus_wait_seq`

## Requirements
- R1: While and right after reset, `cs_active` and `cyc_done` are 0 and `rd_n` is 1. With `lane_mode`=0 the idle lane pins are `lane_p0_n`=1, `lane_p1_n`=1, `lane_p2`=0.
- R2: A short-family read (region 1, 3, 4, 5 or 7) whose selected enable bit is 0 lasts exactly 1 state, whatever `wait_n` does.
- R3: A short-family access that honours the pin lasts 2 states plus one state for each low sample of `wait_n`. Sampling starts at the clock edge that ends the first state and repeats at the end of every inserted state until a high sample.
- R4: A long-family read (region 0, 2 or 6) whose selected enable bit is 0 lasts 1 + L states, where L is `long_wait`+1 (field 0..3 gives 1..4). `wait_n` has no effect.
- R5: A long-family access that honours the pin lasts 1 + L states plus one per low sample. `wait_n` is first sampled at the edge just before the last long-wait state, that is, at the end of state L of the access.
- R6: CPU and dual-mode writes (`req_dma_single`=0) always honour the pin, whatever the enable masks hold.
- R7: Single-mode transfers (`req_dma_single`=1), reads and writes alike, take their enable bit from `wen_single`. CPU and dual-mode reads take it from `wen_normal`. The bit index is the region number.
- R8: Region 3 treats `wait_n` as always high. Its pin-honouring accesses last exactly 2 states.
- R9: `cs_active` is 1 in every state of an access. For a read, `rd_n` is 0 in every state. For a write, `rd_n` stays 1.
- R10: Lane pins with `lane_mode`=0: `lane_p0_n` is the upper-byte write strobe, `lane_p1_n` is the lower-byte write strobe, and `lane_p2` is address bit 0 (1 only for a lower-byte-only access). With `lane_mode`=1: `lane_p0_n` is a common write strobe, `lane_p1_n` is the lower-byte select and `lane_p2` is the upper-byte select, all active low for the whole access.
- R11: `cyc_done` is a one-state pulse in the final state. The request is captured only when idle. Changes to `req_valid` or the request fields during an access are ignored, and at least one idle state follows every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one state per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, taken when idle |
| req_area | input | 3 | Region number 0..7 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dma_single | input | 1 | 1 = DMA single-mode cycle |
| req_hi | input | 1 | Upper byte lane involved |
| req_lo | input | 1 | Lower byte lane involved |
| wen_normal | input | 8 | Per-region pin-wait enables, CPU/dual reads |
| wen_single | input | 8 | Per-region pin-wait enables, single-mode cycles |
| long_wait | input | 2 | Long-wait count minus one |
| lane_mode | input | 1 | Lane pin meaning select |
| wait_n | input | 1 | Active-low wait pin |
| cs_active | output | 1 | Address / chip-select valid window |
| rd_n | output | 1 | Read strobe, active low |
| lane_p0_n | output | 1 | Upper write strobe or common write strobe |
| lane_p1_n | output | 1 | Lower write strobe or lower byte select |
| lane_p2 | output | 1 | Address bit 0 or upper byte select (active low) |
| cyc_done | output | 1 | One-state pulse on the final state |

## Verification
The request is driven at a falling edge and captured at the next rising edge. Every output is decoded from registered state, so the first state of the access is visible at the falling edge that follows the capture, and state k of the access is visible k falling edges later. During state k the bench drives `wait_n` for the rising edge that closes that state. It also samples the strobes and `cyc_done` at that falling edge, so each measured length counts exactly the states between capture and the done pulse. The expected length comes from the region family, the enable rule and the number of low samples. For the long family, the first sample in the hold pattern that counts is the one closing state L. One state after done, the bench confirms the return to idle.

// File: rtl/xbus_pkg.sv
// Package: shared constants and types for the external bus wait-state sequencer.
// Assumes eight regions and a two-bit long-wait field.
package xbus_pkg;

    parameter int XB_LW_W = 2;

    // Access phases, one clock each.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_FIRST = 3'd1,
        PH_LONG  = 3'd2,
        PH_PIN   = 3'd3,
        PH_LAST  = 3'd4
    } xb_phase_e;

    // Shape of one access, settled when the request is taken.
    typedef struct packed {
        logic               one_state;   // access ends in its first state
        logic               pin_sample;  // wait pin is honoured
        logic [XB_LW_W-1:0] pre_last;    // long waits before the final one
    } xb_plan_t;

endpackage

// File: rtl/xbus_cycle_plan.sv
// Module: xbus_cycle_plan
// Turns a request into an access shape: one-state flag, wait-pin honouring
// and the number of long-wait states before the final state.
// Assumes the masks mark long-family regions and regions without a wait pin.
module xbus_cycle_plan
    import xbus_pkg::*;
#(
    parameter int             AREAS      = 8,
    parameter logic [AREAS-1:0] LONG_MASK  = 8'b0100_0101,
    parameter logic [AREAS-1:0] NOPIN_MASK = 8'b0000_1000,
    localparam int            AREA_W     = $clog2(AREAS)
) (
    input  logic [AREA_W-1:0]  area,
    input  logic               write,
    input  logic               dma_single,
    input  logic [AREAS-1:0]   wen_normal,
    input  logic [AREAS-1:0]   wen_single,
    input  logic [XB_LW_W-1:0] long_wait,
    output xb_plan_t           plan
);

    logic is_long;
    logic sel_bit;
    logic honour;

    // Pick the enable source and decide whether the wait pin applies.
    always_comb begin
        is_long = LONG_MASK[area];
        sel_bit = dma_single ? wen_single[area] : wen_normal[area];
        // Plain writes ignore the enable mask; single-mode writes use it.
        honour  = (write && !dma_single) ? 1'b1 : sel_bit;
    end

    // Build the shape record.
    always_comb begin
        plan.one_state  = !is_long && !honour;
        plan.pin_sample = honour && !NOPIN_MASK[area];
        plan.pre_last   = is_long ? long_wait : '0;
    end

endmodule

// File: rtl/xbus_state_seq.sv
// Module: xbus_state_seq
// Walks an access one state per clock. The first state either ends the
// access or leads to the pre-final long waits. Wait-pin states follow when
// the pin is honoured and sampled low, and the final state closes the access.
// Assumes requests are taken only when idle.
module xbus_state_seq
    import xbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  xb_plan_t plan,
    input  logic     req_write,
    input  logic     req_hi,
    input  logic     req_lo,
    input  logic     wait_n,
    output logic     active,
    output logic     done,
    output logic     cur_write,
    output logic     cur_hi,
    output logic     cur_lo
);

    xb_phase_e          phase_q, phase_d;
    logic [XB_LW_W-1:0] left_q, left_d;
    logic               samp_q, one_q;
    logic               held_low;

    assign held_low = samp_q && !wait_n;

    // Next phase and remaining pre-final long waits.
    always_comb begin
        phase_d = phase_q;
        left_d  = left_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    phase_d = PH_FIRST;
                    left_d  = plan.pre_last;
                end
            end
            PH_FIRST, PH_LONG: begin
                if (phase_q == PH_FIRST && one_q) begin
                    phase_d = PH_IDLE;
                end else if (left_q != '0) begin
                    phase_d = PH_LONG;
                    left_d  = left_q - 1'b1;
                end else if (held_low) begin
                    phase_d = PH_PIN;
                end else begin
                    phase_d = PH_LAST;
                end
            end
            PH_PIN: begin
                if (!held_low) phase_d = PH_LAST;
            end
            PH_LAST: phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            left_q  <= '0;
        end else begin
            phase_q <= phase_d;
            left_q  <= left_d;
        end
    end

    // Capture the request attributes at acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q    <= 1'b0;
            one_q     <= 1'b0;
            cur_write <= 1'b0;
            cur_hi    <= 1'b0;
            cur_lo    <= 1'b0;
        end else if (phase_q == PH_IDLE && req_valid) begin
            samp_q    <= plan.pin_sample;
            one_q     <= plan.one_state;
            cur_write <= req_write;
            cur_hi    <= req_hi;
            cur_lo    <= req_lo;
        end
    end

    // Window and completion flags decoded from the phase.
    always_comb begin
        active = (phase_q != PH_IDLE);
        done   = (phase_q == PH_LAST) || (phase_q == PH_FIRST && one_q);
    end

endmodule

// File: rtl/xbus_lane_map.sv
// Module: xbus_lane_map
// Drives the read strobe and the three byte-lane pins from the captured
// access. The lane mode picks separate upper/lower write strobes with
// address bit 0, or a common write strobe with two byte selects.
// Assumes a 16-bit bus with the upper byte at the even address.
module xbus_lane_map (
    input  logic active,
    input  logic write,
    input  logic hi,
    input  logic lo,
    input  logic mode,
    output logic rd_n,
    output logic p0_n,
    output logic p1_n,
    output logic p2
);

    // Read strobe over the whole access.
    always_comb rd_n = !(active && !write);

    // Lane pin meaning chosen by the mode input.
    always_comb begin
        if (mode) begin
            p0_n = !(active && write);
            p1_n = !(active && lo);
            p2   = !(active && hi);
        end else begin
            p0_n = !(active && write && hi);
            p1_n = !(active && write && lo);
            p2   = active && lo && !hi;
        end
    end

endmodule

// File: rtl/xbus_wait_seq.sv
// Module: xbus_wait_seq (top)
// External static-memory bus wait-state sequencer: settles the shape of an
// access, walks its states and drives the window, strobes and done flag.
// Assumes all configuration inputs are steady while an access runs.
module xbus_wait_seq
    import xbus_pkg::*;
#(
    parameter int               AREAS      = 8,
    parameter logic [AREAS-1:0] LONG_MASK  = 8'b0100_0101,
    parameter logic [AREAS-1:0] NOPIN_MASK = 8'b0000_1000,
    localparam int              AREA_W     = $clog2(AREAS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AREA_W-1:0] req_area,
    input  logic              req_write,
    input  logic              req_dma_single,
    input  logic              req_hi,
    input  logic              req_lo,
    input  logic [AREAS-1:0]  wen_normal,
    input  logic [AREAS-1:0]  wen_single,
    input  logic [XB_LW_W-1:0] long_wait,
    input  logic              lane_mode,
    input  logic              wait_n,
    output logic              cs_active,
    output logic              rd_n,
    output logic              lane_p0_n,
    output logic              lane_p1_n,
    output logic              lane_p2,
    output logic              cyc_done
);

    xb_plan_t plan;
    logic     cur_write, cur_hi, cur_lo;

    xbus_cycle_plan #(
        .AREAS      (AREAS),
        .LONG_MASK  (LONG_MASK),
        .NOPIN_MASK (NOPIN_MASK)
    ) u_plan (
        .area       (req_area),
        .write      (req_write),
        .dma_single (req_dma_single),
        .wen_normal (wen_normal),
        .wen_single (wen_single),
        .long_wait  (long_wait),
        .plan       (plan)
    );

    xbus_state_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .plan      (plan),
        .req_write (req_write),
        .req_hi    (req_hi),
        .req_lo    (req_lo),
        .wait_n    (wait_n),
        .active    (cs_active),
        .done      (cyc_done),
        .cur_write (cur_write),
        .cur_hi    (cur_hi),
        .cur_lo    (cur_lo)
    );

    xbus_lane_map u_lane (
        .active (cs_active),
        .write  (cur_write),
        .hi     (cur_hi),
        .lo     (cur_lo),
        .mode   (lane_mode),
        .rd_n   (rd_n),
        .p0_n   (lane_p0_n),
        .p1_n   (lane_p1_n),
        .p2     (lane_p2)
    );

endmodule

// File: rtl/xbus_wait_seq_chk.sv
// Module: xbus_wait_seq_chk
// Port-level timing properties of the sequencer, bound to the top module.
// Assumes the default region families (long: 0, 2, 6; no pin: 3).
module xbus_wait_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_area,
    input logic       req_write,
    input logic       req_dma_single,
    input logic [7:0] wen_normal,
    input logic [1:0] long_wait,
    input logic       cs_active,
    input logic       rd_n,
    input logic       lane_p0_n,
    input logic       cyc_done
);

    logic long_area;
    assign long_area = (req_area == 3'd0) || (req_area == 3'd2) || (req_area == 3'd6);

    // Reset leaves the bus idle on the next state.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!cs_active && !cyc_done && rd_n));

    // Short-family read without pin waits ends in its first state.
    assert_short_one_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cs_active && !req_write && !req_dma_single && !long_area
         && !wen_normal[req_area]) |=> cyc_done);

    // Long-family read, one long wait, no pin waits: done in second state.
    assert_long_two_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cs_active && !req_write && !req_dma_single && long_area
         && !wen_normal[req_area] && long_wait == 2'd0) |=> (!cyc_done ##1 cyc_done));

    // Region 3 plain write ignores the pin: exactly two states.
    assert_area3_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cs_active && req_write && !req_dma_single && req_area == 3'd3)
        |=> (!cyc_done ##1 cyc_done));

    // Read strobe never overlaps the write strobe.
    assert_rd_not_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> lane_p0_n);

    // Done only inside the window and always followed by an idle state.
    assert_done_in_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> cs_active);
    assert_idle_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cs_active);

endmodule

bind xbus_wait_seq xbus_wait_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_area       (req_area),
    .req_write      (req_write),
    .req_dma_single (req_dma_single),
    .wen_normal     (wen_normal),
    .long_wait      (long_wait),
    .cs_active      (cs_active),
    .rd_n           (rd_n),
    .lane_p0_n      (lane_p0_n),
    .cyc_done       (cyc_done)
);

// File: tb/xbus_wait_seq_bench.sv
`timescale 1ns/1ps
// Directed bench for xbus_wait_seq: one task per scenario.
module xbus_wait_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_area = 3'd0;
    logic       req_write = 1'b0;
    logic       req_dma_single = 1'b0;
    logic       req_hi = 1'b1;
    logic       req_lo = 1'b1;
    logic [7:0] wen_normal = 8'h00;
    logic [7:0] wen_single = 8'h00;
    logic [1:0] long_wait = 2'd0;
    logic       lane_mode = 1'b0;
    logic       wait_n = 1'b1;
    logic       cs_active, rd_n, lane_p0_n, lane_p1_n, lane_p2, cyc_done;

    int total = 0;
    int bad = 0;

    // Results of the last access.
    int   r_states;
    logic r_idle_ok;
    logic r_rd_all_low, r_rd_any_low;
    logic r_p0, r_p1, r_p2;

    always #4 clk = ~clk;

    xbus_wait_seq u_xbus_wait_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_area(req_area),
        .req_write(req_write), .req_dma_single(req_dma_single),
        .req_hi(req_hi), .req_lo(req_lo), .wen_normal(wen_normal),
        .wen_single(wen_single), .long_wait(long_wait), .lane_mode(lane_mode),
        .wait_n(wait_n), .cs_active(cs_active), .rd_n(rd_n),
        .lane_p0_n(lane_p0_n), .lane_p1_n(lane_p1_n), .lane_p2(lane_p2),
        .cyc_done(cyc_done)
    );

    task automatic check_int(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Run one access; wait_n is low for the first `hold` states.
    task automatic run_cycle(input logic [2:0] area, input logic wr, input logic dma,
                             input logic hi, input logic lo, input int hold,
                             input bit keep);
        @(negedge clk);
        req_valid = 1'b1; req_area = area; req_write = wr; req_dma_single = dma;
        req_hi = hi; req_lo = lo;
        wait_n = (hold > 0) ? 1'b0 : 1'b1;
        r_states = 0; r_idle_ok = 1'b0;
        r_rd_all_low = 1'b1; r_rd_any_low = 1'b0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (!keep) req_valid = 1'b0;
            else begin
                req_area = area ^ 3'd5;
                req_write = !wr;
            end
            if (k == 0) begin
                r_p0 = lane_p0_n; r_p1 = lane_p1_n; r_p2 = lane_p2;
            end
            if (!cs_active) begin
                r_states = -1;
                break;
            end
            if (rd_n) r_rd_all_low = 1'b0; else r_rd_any_low = 1'b1;
            wait_n = (k < hold) ? 1'b0 : 1'b1;
            if (cyc_done) begin
                r_states = k + 1;
                break;
            end
        end
        @(negedge clk);
        r_idle_ok = !cs_active && !cyc_done && rd_n;
        req_valid = 1'b0;
        wait_n = 1'b1;
    endtask

    task automatic t_reset;
        check_int("R1 cs_active", int'(cs_active), 0);
        check_int("R1 done", int'(cyc_done), 0);
        check_int("R1 rd_n", int'(rd_n), 1);
        check_int("R1 idle lanes", int'({lane_p0_n, lane_p1_n, lane_p2}), 3'b110);
    endtask

    task automatic t_short_plain;
        wen_normal = 8'h00;
        run_cycle(3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 0);
        check_int("R2 area1 read", r_states, 1);
        run_cycle(3'd5, 1'b0, 1'b0, 1'b1, 1'b1, 3, 0);
        check_int("R2 area5 read wait ignored", r_states, 1);
        check_int("R9 rd low", int'(r_rd_all_low), 1);
    endtask

    task automatic t_short_wait;
        wen_normal = 8'b1011_0010;
        run_cycle(3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 0, 0);
        check_int("R3 area4 no low", r_states, 2);
        run_cycle(3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 3, 0);
        check_int("R3 area7 three lows", r_states, 5);
        check_int("R9 rd low through waits", int'(r_rd_all_low), 1);
    endtask

    task automatic t_long_plain;
        wen_normal = 8'h00;
        for (int lw = 0; lw < 4; lw++) begin
            long_wait = 2'(lw);
            run_cycle(3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 6, 0);
            check_int("R4 area2 long read", r_states, 2 + lw);
        end
    endtask

    task automatic t_long_wait;
        wen_normal = 8'b0100_0101;
        long_wait = 2'd2;
        run_cycle(3'd6, 1'b0, 1'b0, 1'b1, 1'b1, 2, 0);
        check_int("R5 lows before sample point", r_states, 4);
        run_cycle(3'd6, 1'b0, 1'b0, 1'b1, 1'b1, 5, 0);
        check_int("R5 three counted lows", r_states, 7);
        long_wait = 2'd0;
        run_cycle(3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2, 0);
        check_int("R5 one long wait two lows", r_states, 4);
    endtask

    task automatic t_writes;
        wen_normal = 8'h00;
        long_wait = 2'd1;
        run_cycle(3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 2, 0);
        check_int("R6 short write", r_states, 4);
        check_int("R9 no rd on write", int'(r_rd_any_low), 0);
        run_cycle(3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 3, 0);
        check_int("R6 long write", r_states, 5);
    endtask

    task automatic t_single;
        wen_normal = 8'b0001_0000;
        wen_single = 8'b0000_0000;
        run_cycle(3'd4, 1'b0, 1'b1, 1'b1, 1'b1, 2, 0);
        check_int("R7 single read uses wen_single", r_states, 1);
        run_cycle(3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 2, 0);
        check_int("R7 single write uses wen_single", r_states, 1);
        wen_normal = 8'h00;
        wen_single = 8'b0001_0000;
        run_cycle(3'd4, 1'b0, 1'b1, 1'b1, 1'b1, 2, 0);
        check_int("R7 single read enabled", r_states, 4);
        run_cycle(3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 2, 0);
        check_int("R7 normal read disabled", r_states, 1);
    endtask

    task automatic t_area3;
        wen_normal = 8'b0000_1000;
        run_cycle(3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 4, 0);
        check_int("R8 area3 read", r_states, 2);
        run_cycle(3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 4, 0);
        check_int("R8 area3 write", r_states, 2);
    endtask

    task automatic t_lanes;
        wen_normal = 8'h00;
        lane_mode = 1'b0;
        run_cycle(3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 0, 0);
        check_int("R10 mode0 upper write", int'({r_p0, r_p1, r_p2}), 3'b010);
        run_cycle(3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 0, 0);
        check_int("R10 mode0 lower write", int'({r_p0, r_p1, r_p2}), 3'b101);
        run_cycle(3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 0, 0);
        check_int("R10 mode0 word write", int'({r_p0, r_p1, r_p2}), 3'b000);
        run_cycle(3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 0, 0);
        check_int("R10 mode0 lower read", int'({r_p0, r_p1, r_p2}), 3'b111);
        lane_mode = 1'b1;
        run_cycle(3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 0, 0);
        check_int("R10 mode1 lower read", int'({r_p0, r_p1, r_p2}), 3'b101);
        run_cycle(3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 0, 0);
        check_int("R10 mode1 word write", int'({r_p0, r_p1, r_p2}), 3'b000);
        run_cycle(3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 0, 0);
        check_int("R10 mode1 upper write", int'({r_p0, r_p1, r_p2}), 3'b010);
        lane_mode = 1'b0;
    endtask

    task automatic t_busy_ignore;
        wen_normal = 8'b1000_0000;
        run_cycle(3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1, 1);
        check_int("R11 held request ignored length", r_states, 3);
        check_int("R11 idle after done", int'(r_idle_ok), 1);
        run_cycle(3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 0);
        check_int("R11 next access", r_states, 1);
        check_int("R11 idle after short access", int'(r_idle_ok), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_plain();
        t_short_wait();
        t_long_plain();
        t_long_wait();
        t_writes();
        t_single();
        t_area3();
        t_lanes();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule